// File: doc/BRIEF.md
# Prepared jump target unit

This unit lives in a processor front end and lets software name the destination of a jump well before the jump itself reaches fetch. Each cycle the decoder may hand over a group of up to three instruction slots. A slot can carry a set operation, which records a jump destination, or a jump operation, which consumes it. The set operation comes in two forms. One stores a fixed address. The other picks one of two addresses according to a condition value.

A jump operation is always taken. When the recorded destination has been stable for enough whole groups, the unit redirects fetch to exactly that address. When it has not, the unit passes on the branch predictor's address and raises a fallback flag. The four groups of margin cover the front-end stages that lie between fetch and the point where a condition becomes known. A flush input throws away the recorded destination.

Top module: `jump_prep_unit`

## Requirements
- R1: Slot i uses `slot_op[2i+1:2i]`, with 00 meaning no operation, 01 a fixed set, 10 a conditional set and 11 a jump. A fixed set records `slot_tgt0` of its slot.
- R2: A conditional set records `slot_tgt0` of its slot when that slot's `slot_cond` field is all zeros, and `slot_tgt1` when the field is anything else.
- R3: A jump whose group follows the set's group with at least LATENCY (default 4) accepted groups in between redirects to the recorded address with `used_fallback` low. The result appears on the outputs in the cycle after the jump's group.
- R4: A jump whose target is not settled outputs `pred_addr` with `used_fallback` high. This covers fewer than LATENCY groups since the set, no target recorded, and a set in an earlier slot of the same group.
- R5: Every jump discards the recorded target. A second jump with no new set in between falls back.
- R6: Slots after the first jump in a group are ignored, including any set operations they carry.
- R7: `redir_valid` is high for exactly the cycle after an accepted group (`grp_valid` high) that contains a jump. `used_fallback` is low whenever `redir_valid` is low.
- R8: `flush` clears the recorded target and its age, and the group presented in the same cycle is dropped.
- R9: While reset is active, and in the first cycle after it, `redir_valid` and `used_fallback` are low and no target is recorded.
- R10: The age of a target advances only on accepted groups. Cycles with `grp_valid` low neither age the target nor produce a redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Pipeline flush; clears the recorded target |
| grp_valid | input | 1 | A decoded group is presented this cycle |
| slot_op | input | 2*SLOTS | Per-slot operation code |
| slot_cond | input | CW*SLOTS | Per-slot condition value for conditional sets |
| slot_tgt0 | input | AW*SLOTS | Per-slot first or fixed target |
| slot_tgt1 | input | AW*SLOTS | Per-slot second target |
| pred_addr | input | AW | Branch predictor's target for a jump in this group |
| redir_valid | output | 1 | Fetch redirect is present |
| redir_addr | output | AW | Fetch redirect address |
| used_fallback | output | 1 | Redirect came from the predictor address |

## Verification
Every redirect shows up exactly one clock after the group that carried its jump, because a single register stage sits between the slot inputs and the outputs. State changes from a set or a flush become visible only through a later jump. The bench therefore drives each group just after a falling edge, lets one rising edge pass, and samples at the next falling edge. It compares against a model that it advances in step with the stimulus. The directed cases place jumps exactly LATENCY and LATENCY-1 groups after a set, and also put idle cycles inside that window.

// File: rtl/jump_prep_unit.sv
module jump_prep_unit #(
  parameter int SLOTS   = 3,
  parameter int AW      = 32,
  parameter int CW      = 8,
  parameter int LATENCY = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  grp_valid,
  input  logic [2*SLOTS-1:0]    slot_op,
  input  logic [CW*SLOTS-1:0]   slot_cond,
  input  logic [AW*SLOTS-1:0]   slot_tgt0,
  input  logic [AW*SLOTS-1:0]   slot_tgt1,
  input  logic [AW-1:0]         pred_addr,
  output logic                  redir_valid,
  output logic [AW-1:0]         redir_addr,
  output logic                  used_fallback
);
  localparam int AGW = $clog2(LATENCY + 1);
  localparam logic [AGW-1:0] AGE_MAX = AGW'(LATENCY);
  localparam logic [1:0] OP_SETF = 2'b01;
  localparam logic [1:0] OP_SETC = 2'b10;
  localparam logic [1:0] OP_JUMP = 2'b11;

  logic [AW-1:0]  tgt_q, tgt_d;
  logic           valid_q, valid_d;
  logic [AGW-1:0] age_q, age_d;
  logic           hit, settled, fresh, stop;

  always_comb begin
    tgt_d   = tgt_q;
    valid_d = valid_q;
    age_d   = (age_q == AGE_MAX) ? age_q : age_q + 1'b1;
    hit     = 1'b0;
    settled = 1'b0;
    fresh   = 1'b0;
    stop    = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (!stop) begin
        case (slot_op[2*i +: 2])
          OP_SETF: begin
            tgt_d = slot_tgt0[AW*i +: AW];
            valid_d = 1'b1; age_d = '0; fresh = 1'b1;
          end
          OP_SETC: begin
            tgt_d = (slot_cond[CW*i +: CW] == '0) ? slot_tgt0[AW*i +: AW]
                                                  : slot_tgt1[AW*i +: AW];
            valid_d = 1'b1; age_d = '0; fresh = 1'b1;
          end
          OP_JUMP: begin
            hit     = 1'b1;
            settled = valid_q && !fresh && (age_q == AGE_MAX);
            valid_d = 1'b0;
            stop    = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      tgt_q         <= '0;
      valid_q       <= 1'b0;
      age_q         <= '0;
      redir_valid   <= 1'b0;
      used_fallback <= 1'b0;
      if (!rst_n) redir_addr <= '0;
    end else if (grp_valid) begin
      tgt_q         <= tgt_d;
      valid_q       <= valid_d;
      age_q         <= age_d;
      redir_valid   <= hit;
      used_fallback <= hit && !settled;
      if (hit) redir_addr <= settled ? tgt_q : pred_addr;
    end else begin
      redir_valid   <= 1'b0;
      used_fallback <= 1'b0;
    end
  end
endmodule

// File: rtl/jump_prep_unit_chk.sv
module jump_prep_unit_chk #(
  parameter int AW      = 32,
  parameter int LATENCY = 4,
  parameter int AGW     = $clog2(LATENCY + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           flush,
  input logic           grp_valid,
  input logic [AW-1:0]  pred_addr,
  input logic           redir_valid,
  input logic [AW-1:0]  redir_addr,
  input logic           used_fallback,
  input logic [AGW-1:0] age
);
  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_n |=> !redir_valid && !used_fallback);

  assert_age_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    age <= AGW'(LATENCY));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_valid && !flush |=> $stable(age) && !redir_valid);

  assert_flush_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !redir_valid && age == '0);

  assert_fb_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !redir_valid |-> !used_fallback);

  assert_fb_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid && used_fallback |-> redir_addr == $past(pred_addr));

  assert_back_to_back_R5: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid && $past(redir_valid) |-> used_fallback);
endmodule

bind jump_prep_unit jump_prep_unit_chk #(.AW(AW), .LATENCY(LATENCY)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .grp_valid(grp_valid),
  .pred_addr(pred_addr), .redir_valid(redir_valid), .redir_addr(redir_addr),
  .used_fallback(used_fallback), .age(age_q)
);

// File: tb/test_jump_prep_unit.sv
module test_jump_prep_unit;
  localparam int SLOTS = 3, AW = 32, CW = 8, LAT = 4;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, grp_valid = 1'b0;
  logic [2*SLOTS-1:0]  slot_op = '0;
  logic [CW*SLOTS-1:0] slot_cond = '0;
  logic [AW*SLOTS-1:0] slot_tgt0 = '0, slot_tgt1 = '0;
  logic [AW-1:0]       pred_addr = '0;
  logic                redir_valid, used_fallback;
  logic [AW-1:0]       redir_addr;

  int n_chk = 0, n_fail = 0, cycles = 0;
  logic [AW-1:0] m_tgt = '0;
  bit m_valid = 0;
  int m_age = 0;

  always #10 clk = ~clk;

  jump_prep_unit #(.SLOTS(SLOTS), .AW(AW), .CW(CW), .LATENCY(LAT)) i_jump_prep_unit (
    .clk(clk), .rst_n(rst_n), .flush(flush), .grp_valid(grp_valid),
    .slot_op(slot_op), .slot_cond(slot_cond), .slot_tgt0(slot_tgt0),
    .slot_tgt1(slot_tgt1), .pred_addr(pred_addr), .redir_valid(redir_valid),
    .redir_addr(redir_addr), .used_fallback(used_fallback));

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R7 actual=%0d expected<=100000 cycles", cycles);
      finish_run();
    end
  end

  task automatic chk(input string tag, input string what, input logic [AW-1:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit g, f, input logic [2*SLOTS-1:0] ops,
                      input logic [CW*SLOTS-1:0] conds,
                      input logic [AW*SLOTS-1:0] t0s, t1s,
                      input logic [AW-1:0] pa, input string tag);
    bit ev = 0, ef = 0, stop = 0, fresh = 0;
    logic [AW-1:0] ea = '0;
    grp_valid = g; flush = f; slot_op = ops; slot_cond = conds;
    slot_tgt0 = t0s; slot_tgt1 = t1s; pred_addr = pa;
    if (f) begin
      m_tgt = '0; m_valid = 0; m_age = 0;
    end else if (g) begin
      logic [AW-1:0] nt = m_tgt;
      bit nv = m_valid;
      int na = (m_age < LAT) ? m_age + 1 : LAT;
      for (int i = 0; i < SLOTS; i++) begin
        if (!stop) begin
          logic [1:0] op = ops[2*i +: 2];
          if (op == 2'b01 || op == 2'b10) begin
            nt = (op == 2'b01 || conds[CW*i +: CW] == '0) ? t0s[AW*i +: AW] : t1s[AW*i +: AW];
            nv = 1; na = 0; fresh = 1;
          end else if (op == 2'b11) begin
            ev = 1;
            if (m_valid && !fresh && m_age == LAT) ea = m_tgt;
            else begin ea = pa; ef = 1; end
            nv = 0; stop = 1;
          end
        end
      end
      m_tgt = nt; m_valid = nv; m_age = na;
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "redir_valid", AW'(redir_valid), AW'(ev));
    chk(tag, "used_fallback", AW'(used_fallback), AW'(ef));
    if (ev) chk(tag, "redir_addr", redir_addr, ea);
  endtask

  task automatic idle_groups(input int n);
    for (int k = 0; k < n; k++) step(1, 0, '0, '0, '0, '0, 32'h0, "R10");
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (2) @(negedge clk);
    chk("R9", "redir_valid", AW'(redir_valid), '0);
    chk("R9", "used_fallback", AW'(used_fallback), '0);
    rst_n = 1'b1;
    step(1, 0, 6'b000011, '0, '0, '0, 32'hB000_0000, "R9");
    // R1 / R3: fixed set, exactly LATENCY groups between
    step(1, 0, 6'b000001, '0, {64'h0, 32'h0000_1000}, '0, 32'h0, "R1");
    idle_groups(LAT);
    step(1, 0, 6'b000011, '0, '0, '0, 32'hBAD0_0001, "R3");
    // R5: second jump without new set
    step(1, 0, 6'b000011, '0, '0, '0, 32'hBAD0_0002, "R5");
    // R4: one group too young
    step(1, 0, 6'b000001, '0, {64'h0, 32'h0000_2000}, '0, 32'h0, "R4");
    idle_groups(LAT - 1);
    step(1, 0, 6'b000011, '0, '0, '0, 32'hBAD0_0003, "R4");
    // R4: set and jump in the same group
    step(1, 0, 6'b001101, '0, {64'h0, 32'h0000_3000}, '0, 32'hBAD0_0004, "R4");
    // R2: conditional set, zero then nonzero
    step(1, 0, 6'b000010, 24'h0, {64'h0, 32'h0000_4000}, {64'h0, 32'h0000_5000}, 32'h0, "R2");
    idle_groups(LAT);
    step(1, 0, 6'b000011, '0, '0, '0, 32'hBAD0_0005, "R2");
    step(1, 0, 6'b000010, 24'h05, {64'h0, 32'h0000_4000}, {64'h0, 32'h0000_5000}, 32'h0, "R2");
    idle_groups(LAT);
    step(1, 0, 6'b000011, '0, '0, '0, 32'hBAD0_0006, "R2");
    // R6: set after jump in same group is discarded
    step(1, 0, 6'b000111, '0, {32'h0, 32'h0000_6000, 32'h0}, '0, 32'hBAD0_0007, "R6");
    idle_groups(LAT);
    step(1, 0, 6'b000011, '0, '0, '0, 32'hBAD0_0008, "R6");
    // R10: idle cycles do not age the target
    step(1, 0, 6'b000001, '0, {64'h0, 32'h0000_7000}, '0, 32'h0, "R10");
    idle_groups(2);
    for (int k = 0; k < 3; k++) step(0, 0, 6'b000011, '0, '0, '0, 32'h0, "R10");
    idle_groups(1);
    step(1, 0, 6'b000011, '0, '0, '0, 32'hBAD0_0009, "R10");
    // R8: flush drops target and same-cycle jump
    step(1, 0, 6'b000001, '0, {64'h0, 32'h0000_8000}, '0, 32'h0, "R8");
    idle_groups(LAT);
    step(1, 1, 6'b000011, '0, '0, '0, 32'h0, "R8");
    idle_groups(LAT);
    step(1, 0, 6'b000011, '0, '0, '0, 32'hBAD0_000A, "R8");
    // R7: no group, no redirect
    step(0, 0, 6'b111111, '0, '0, '0, 32'h0, "R7");
    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [2*SLOTS-1:0]  ops;
      logic [CW*SLOTS-1:0] cs;
      logic [AW*SLOTS-1:0] a0, a1;
      for (int s = 0; s < SLOTS; s++) begin
        int r = $urandom_range(99);
        ops[2*s +: 2] = (r < 60) ? 2'b00 : (r < 72) ? 2'b01 : (r < 84) ? 2'b10 : 2'b11;
        cs[CW*s +: CW] = ($urandom_range(2) == 0) ? 8'h0 : 8'($urandom);
        a0[AW*s +: AW] = $urandom;
        a1[AW*s +: AW] = $urandom;
      end
      step($urandom_range(9) != 0, $urandom_range(39) == 0, ops, cs, a0, a1, $urandom,
           "R3 R4 random");
    end
    finish_run();
  end
endmodule